// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address Sequencer

This block is a single-port synchronous SRAM that keeps its own four-beat burst address sequencer. On every accepted cycle the caller either loads a fresh start address (advance low) or asks the sequencer to step to the next address of the current burst (advance high). A stepped beat reuses the read or write direction latched at load time. The sequence walks the two low address bits either as a linear count or as an XOR with the beat number. That choice is a static select, and the upper address bits stay fixed for the whole burst.

Read data comes back one cycle after the command in flow-through timing and two cycles after it in pipelined timing. Write data is taken late, at the same distance after its command, so that the data bus sees one beat per command slot in either direction and reads and writes can alternate every cycle with no turnaround. Writes that have been accepted but whose data has not yet reached the array are forwarded to later reads, lane by lane. A sleep input stops new commands from being accepted while the array and the burst state are preserved. Pipelined timing is the intended default configuration.

The read-return stream carries a valid flag and has no ready input. There is no back-pressure: the consumer must take every beat in the cycle it is flagged. The command side is a plain per-cycle control interface.

Top module: `burst_sram`

## Requirements
- R1: A cycle with `cmd_en`=1, `sleep`=0 and `cmd_adv`=0 accesses `cmd_addr` directly, makes it the start of a new burst, resets the beat number to 0 and latches `cmd_we` as the burst direction.
- R2: A cycle with `cmd_en`=1, `sleep`=0 and `cmd_adv`=1 after a load increments the beat number (2-bit, modulo 4) and accesses the sequenced address in the latched direction, whatever `cmd_we` is. An advance with no burst loaded since reset does nothing.
- R3: With `order_sel`=0, the access address of beat n is the start address with its two low bits replaced by (start[1:0] + n) mod 4. All higher bits equal the start address.
- R4: With `order_sel`=1, the two low bits of beat n are start[1:0] XOR n, and all higher bits equal the start address.
- R5: The fourth advance after a load accesses the start address again.
- R6: A read accepted in cycle c is presented with `rd_valid`=1 in cycle c+1 when `flow_sel`=1 and in cycle c+2 when `flow_sel`=0.
- R7: For a write accepted in cycle c, `wr_data` and `wr_be` are sampled in cycle c+1 (`flow_sel`=1) or c+2 (`flow_sel`=0). Only byte lanes whose `wr_be` bit is 1 change, and bit i of `wr_be` covers `wr_data[8i+7:8i]`.
- R8: A read returns the newest data written to its address by any earlier accepted write, including writes whose late data has not yet reached the array, merged lane by lane.
- R9: Reads and writes may be issued on every consecutive cycle in any mix without idle cycles, and every read returns the value that program order implies.
- R10: While `sleep`=1, no command is accepted, so the array contents and the burst state stay unchanged. Commands accepted before sleep still complete their data beats.
- R11: Whenever `rd_valid`=0, `rd_data` is all zeros. After reset `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Command present this cycle |
| cmd_adv | input | 1 | 1 = step the burst, 0 = load `cmd_addr` |
| cmd_we | input | 1 | 1 = write, 0 = read (used on load only) |
| cmd_addr | input | ADDR_W | Word address for a load |
| wr_be | input | DATA_W/8 | Late byte enables for the pending write |
| wr_data | input | DATA_W | Late write data |
| order_sel | input | 1 | Static: 0 linear, 1 XOR burst order |
| flow_sel | input | 1 | Static: 1 flow-through, 0 pipelined read timing |
| sleep | input | 1 | 1 = standby, no commands accepted |
| rd_valid | output | 1 | Read data beat valid |
| rd_data | output | DATA_W | Read data, zero when not valid |

## Verification
The array is first filled with data derived from each address, so every read shows which address was accessed. Directed linear and XOR bursts from start offsets other than zero then separate the two orders and expose the wrap on the fourth advance. Write-then-read pairs on the same address with partial byte enables, in both timings, separate correct forwarding from a stale array read or whole-word forwarding. Sleep periods placed inside a burst, together with an advance issued right after reset, separate frozen state from state that drifts, and a long random mix of reads and writes under all four mode combinations checks latency and ordering against a program-order reference.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int BURST_LEN = 4;
  localparam int OFS_W     = $clog2(BURST_LEN);
  localparam int LAT_FLOW  = 1;
  localparam int LAT_PIPE  = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  // Low address bits of beat 'step' of a burst starting at 'start'.
  function automatic logic [OFS_W-1:0] burst_offset(
    input logic [OFS_W-1:0] start,
    input logic [OFS_W-1:0] step,
    input burst_order_e     ord
  );
    return (ord == ORDER_XOR) ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              adv,
  input  logic              we_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_sel,
  output logic              acc_v,
  output logic              acc_we,
  output logic [ADDR_W-1:0] acc_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  beat_q;
  logic [OFS_W-1:0]  beat_nx;
  logic              dir_we_q;
  logic              live_q;
  logic              do_load;
  logic              do_step;
  burst_order_e      ord;

  assign ord     = burst_order_e'(order_sel);
  assign do_load = accept && !adv;
  assign do_step = accept && adv && live_q;
  assign beat_nx = beat_q + OFS_W'(1);

  always_comb begin
    acc_v    = do_load || do_step;
    acc_we   = do_load ? we_in : dir_we_q;
    acc_addr = do_load ? addr_in
                       : {base_q[ADDR_W-1:OFS_W], burst_offset(base_q[OFS_W-1:0], beat_nx, ord)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      dir_we_q <= 1'b0;
      live_q   <= 1'b0;
    end else if (do_load) begin
      base_q   <= addr_in;
      beat_q   <= '0;
      dir_we_q <= we_in;
      live_q   <= 1'b1;
    end else if (do_step) begin
      beat_q   <= beat_nx;
    end
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (beat_q == '0) && (base_q == $past(addr_in)) && live_q); // R1

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> (beat_q == $past(beat_q) + OFS_W'(1)) && $stable(base_q)); // R2

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(beat_q) && $stable(base_q) && $stable(dir_we_q)); // R10

  AST_HIGH_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |-> acc_addr[ADDR_W-1:OFS_W] == base_q[ADDR_W-1:OFS_W]); // R3

endmodule

// File: rtl/late_write_pipe.sv
module late_write_pipe #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_sel,
  input  logic              acc_v,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              cmt_v,
  output logic [ADDR_W-1:0] cmt_addr
);

  localparam int STAGES = 2;

  logic              st_w_q    [STAGES];
  logic [ADDR_W-1:0] st_addr_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_w_q[s]    <= 1'b0;
          st_addr_q[s] <= '0;
        end else if (s == 0) begin
          st_w_q[s]    <= acc_v && acc_we;
          st_addr_q[s] <= acc_addr;
        end else begin
          st_w_q[s]    <= st_w_q[s-1];
          st_addr_q[s] <= st_addr_q[s-1];
        end
      end
    end
  endgenerate

  // Flow-through timing commits one stage behind the command, pipelined two.
  assign cmt_v    = flow_sel ? st_w_q[0]    : st_w_q[1];
  assign cmt_addr = flow_sel ? st_addr_q[0] : st_addr_q[1];

  AST_FLOW_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_sel && cmt_v) |-> $past(acc_v && acc_we)); // R7

  AST_PIPE_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_sel && cmt_v) |-> $past(acc_v && acc_we, 2)); // R7

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     wr_v,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W/LANE_W-1:0] wr_be,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [ADDR_W-1:0]        ovl_addr,
  input  logic [DATA_W-1:0]        ovl_in,
  output logic [DATA_W-1:0]        ovl_out
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Replace the enabled lanes of 'base' with the write being committed.
  function automatic logic [DATA_W-1:0] lane_overlay(
    input logic [DATA_W-1:0] base,
    input logic              hit,
    input logic [LANES-1:0]  be,
    input logic [DATA_W-1:0] nd
  );
    logic [DATA_W-1:0] r;
    r = base;
    for (int l = 0; l < LANES; l++) begin
      if (hit && be[l]) r[l*LANE_W +: LANE_W] = nd[l*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_v && wr_be[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
    end
  end

  assign rd_data = lane_overlay(mem[rd_addr], wr_v && (wr_addr == rd_addr),  wr_be, wr_data);
  assign ovl_out = lane_overlay(ovl_in,       wr_v && (wr_addr == ovl_addr), wr_be, wr_data);

endmodule

// File: rtl/read_path.sv
module read_path #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_sel,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [ADDR_W-1:0] mid_addr,
  output logic [DATA_W-1:0] mid_data,
  input  logic [DATA_W-1:0] mid_fixed,
  output logic              out_v,
  output logic [DATA_W-1:0] out_data
);

  logic mid_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_v_q  <= 1'b0;
      mid_addr <= '0;
      mid_data <= '0;
      out_v    <= 1'b0;
      out_data <= '0;
    end else begin
      mid_v_q  <= rd_req && !flow_sel;
      mid_addr <= rd_addr;
      mid_data <= arr_data;
      if (flow_sel) begin
        out_v    <= rd_req;
        out_data <= rd_req ? arr_data : '0;
      end else begin
        out_v    <= mid_v_q;
        out_data <= mid_v_q ? mid_fixed : '0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_v |-> (out_data == '0)); // R11

  AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_sel && rd_req) |=> out_v); // R6

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_req, 2) && $past(!flow_sel, 2) && $past(!flow_sel)) |-> out_v); // R6

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_en,
  input  logic                     cmd_adv,
  input  logic                     cmd_we,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [DATA_W/LANE_W-1:0] wr_be,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     order_sel,
  input  logic                     flow_sel,
  input  logic                     sleep,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int LANES = DATA_W / LANE_W;

  logic              accept;
  logic              acc_v;
  logic              acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic              cmt_v;
  logic [ADDR_W-1:0] cmt_addr;
  logic [DATA_W-1:0] arr_rd;
  logic [ADDR_W-1:0] mid_addr;
  logic [DATA_W-1:0] mid_data;
  logic [DATA_W-1:0] mid_fixed;

  assign accept = cmd_en && !sleep;

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .adv(cmd_adv), .we_in(cmd_we),
    .addr_in(cmd_addr), .order_sel(order_sel),
    .acc_v(acc_v), .acc_we(acc_we), .acc_addr(acc_addr)
  );

  late_write_pipe #(.ADDR_W(ADDR_W)) i_wpipe (
    .clk(clk), .rst_n(rst_n), .flow_sel(flow_sel),
    .acc_v(acc_v), .acc_we(acc_we), .acc_addr(acc_addr),
    .cmt_v(cmt_v), .cmt_addr(cmt_addr)
  );

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) i_array (
    .clk(clk), .wr_v(cmt_v), .wr_addr(cmt_addr), .wr_be(wr_be), .wr_data(wr_data),
    .rd_addr(acc_addr), .rd_data(arr_rd),
    .ovl_addr(mid_addr), .ovl_in(mid_data), .ovl_out(mid_fixed)
  );

  read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rpath (
    .clk(clk), .rst_n(rst_n), .flow_sel(flow_sel),
    .rd_req(acc_v && !acc_we), .rd_addr(acc_addr), .arr_data(arr_rd),
    .mid_addr(mid_addr), .mid_data(mid_data), .mid_fixed(mid_fixed),
    .out_v(rd_valid), .out_data(rd_data)
  );

  initial begin
    AST_LANE_SPLIT: assert (LANES * LANE_W == DATA_W && ADDR_W > OFS_W); // R7
  end

  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !acc_v); // R10

endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_en = 1'b0, cmd_adv = 1'b0, cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [NL-1:0] wr_be = '0;
  logic [DW-1:0] wr_data = '0;
  logic          order_sel = 1'b0, flow_sel = 1'b1, sleep = 1'b0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_adv(cmd_adv), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .wr_be(wr_be), .wr_data(wr_data), .order_sel(order_sel),
    .flow_sel(flow_sel), .sleep(sleep), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";

  // Reference model state
  logic [DW-1:0] ref_mem [1 << AW];
  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;
  logic          m_we, m_live;
  logic          exp_v [4];
  logic [DW-1:0] exp_d [4];
  logic          wd_v  [4];
  logic [DW-1:0] wd_d  [4];
  logic [NL-1:0] wd_be [4];

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [1:0] n,
                                              input logic xo);
    logic [1:0] lo;
    lo = xo ? (b[1:0] ^ n) : (b[1:0] + n);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_slots();
    for (int i = 0; i < 4; i++) begin
      exp_v[i] = 1'b0; wd_v[i] = 1'b0; exp_d[i] = '0; wd_d[i] = '0; wd_be[i] = '0;
    end
  endtask

  task automatic step(input logic en, input logic adv, input logic we, input logic [AW-1:0] a,
                      input logic [NL-1:0] be, input logic [DW-1:0] d, input logic slp);
    int s, t;
    logic hit, w;
    logic [AW-1:0] ea;
    @(negedge clk);
    s = cyc % 4;
    if (exp_v[s]) chk(cur_req, {rd_valid, rd_data}, {1'b1, exp_d[s]});
    else          chk({cur_req, " R11 idle"}, {rd_valid, rd_data}, '0);
    exp_v[s] = 1'b0;
    wr_data  = wd_v[s] ? wd_d[s] : '0;
    wr_be    = wd_v[s] ? wd_be[s] : '0;
    wd_v[s]  = 1'b0;
    cmd_en = en; cmd_adv = adv; cmd_we = we; cmd_addr = a; sleep = slp;
    hit = 1'b0; w = 1'b0; ea = '0;
    if (en && !slp) begin
      if (!adv) begin
        m_base = a; m_beat = 2'd0; m_we = we; m_live = 1'b1;
        ea = a; w = we; hit = 1'b1;
      end else if (m_live) begin
        m_beat = m_beat + 2'd1;
        ea = beat_addr(m_base, m_beat, order_sel); w = m_we; hit = 1'b1;
      end
    end
    if (hit) begin
      t = (cyc + (flow_sel ? 1 : 2)) % 4;
      if (w) begin
        for (int l = 0; l < NL; l++) if (be[l]) ref_mem[ea][l*8 +: 8] = d[l*8 +: 8];
        wd_v[t] = 1'b1; wd_d[t] = d; wd_be[t] = be;
      end else begin
        exp_v[t] = 1'b1; exp_d[t] = ref_mem[ea];
      end
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_en = 1'b0; cmd_adv = 1'b0; sleep = 1'b0; wr_be = '0;
    repeat (2) @(negedge clk);
    chk("R11 reset", {rd_valid, rd_data}, '0);
    rst_n = 1'b1;
    m_live = 1'b0; m_beat = '0; m_base = '0; m_we = 1'b0;
    clear_slots();
  endtask

  task automatic rd(input logic adv, input logic [AW-1:0] a);
    step(1'b1, adv, 1'b0, a, '0, '0, 1'b0);
  endtask

  task automatic wr(input logic adv, input logic [AW-1:0] a, input logic [NL-1:0] be,
                    input logic [DW-1:0] d);
    step(1'b1, adv, 1'b1, a, be, d, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E_ED07));
    clear_slots();
    do_reset();

    // Fill: every word holds a pattern derived from its address
    cur_req = "R7 fill";
    for (int a = 0; a < (1 << AW); a++) wr(1'b0, AW'(a), 2'b11, {~8'(a), 8'(a)});
    idle(3);

    // R3 linear burst, pipelined, advance beats ignore cmd_we (R2), wrap (R5)
    flow_sel = 1'b0; order_sel = 1'b0;
    cur_req = "R1 load";  rd(1'b0, 8'h1E);
    cur_req = "R3 beat1"; step(1'b1, 1'b1, 1'b1, 8'h00, 2'b11, 16'hDEAD, 1'b0);
    cur_req = "R3 beat2"; rd(1'b1, 8'h00);
    cur_req = "R2 beat3"; step(1'b1, 1'b1, 1'b1, 8'h00, 2'b11, 16'hBEEF, 1'b0);
    cur_req = "R5 wrap";  rd(1'b1, 8'h00);
    idle(3);

    // R4 XOR burst, pipelined then flow-through
    order_sel = 1'b1;
    cur_req = "R4 pipe"; rd(1'b0, 8'h2D);
    for (int i = 0; i < 4; i++) rd(1'b1, 8'h00);
    idle(3);
    flow_sel = 1'b1;
    cur_req = "R4 flow"; rd(1'b0, 8'h86);
    for (int i = 0; i < 4; i++) rd(1'b1, 8'h00);
    idle(3);

    // R6 single reads: valid appears only at the exact latency
    cur_req = "R6 flow"; rd(1'b0, 8'h33); idle(3);
    flow_sel = 1'b0;
    cur_req = "R6 pipe"; rd(1'b0, 8'h34); idle(3);

    // R8 forwarding with partial lanes, pipelined then flow-through
    cur_req = "R8 pipe";
    wr(1'b0, 8'h40, 2'b01, 16'hAAAA); rd(1'b0, 8'h40); rd(1'b0, 8'h40);
    wr(1'b0, 8'h40, 2'b10, 16'h5555); idle(1); rd(1'b0, 8'h40);
    idle(3);
    flow_sel = 1'b1;
    cur_req = "R8 flow";
    wr(1'b0, 8'h41, 2'b10, 16'h1234); rd(1'b0, 8'h41);
    wr(1'b0, 8'h41, 2'b01, 16'h9876); rd(1'b0, 8'h41);
    idle(3);

    // R2 write burst: advances keep writing although cmd_we=0
    order_sel = 1'b0;
    cur_req = "R2 wburst";
    wr(1'b0, 8'h52, 2'b11, 16'h0F01);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 8'h00, 2'b11, 16'h0F02 + 16'(i), 1'b0);
    for (int i = 0; i < 4; i++) rd(1'b0, 8'h50 + 8'(i));
    idle(3);

    // R2 advance with no burst after reset does nothing
    do_reset();
    cur_req = "R2 no burst"; rd(1'b1, 8'h10); rd(1'b1, 8'h10); idle(3);

    // R10 sleep: writes ignored, burst state kept across sleep
    cur_req = "R10 sleep";
    step(1'b1, 1'b0, 1'b1, 8'h60, 2'b11, 16'hFFFF, 1'b1);
    step(1'b1, 1'b1, 1'b1, 8'h61, 2'b11, 16'hEEEE, 1'b1);
    idle(1);
    rd(1'b0, 8'h60); rd(1'b0, 8'h61);
    rd(1'b0, 8'h72);
    step(1'b1, 1'b1, 1'b0, 8'h00, 2'b00, 16'h0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 8'h99, 2'b00, 16'h0, 1'b1);
    rd(1'b1, 8'h00); rd(1'b1, 8'h00);
    idle(3);

    // R9 random back-to-back traffic over all mode combinations
    cur_req = "R9 random";
    for (int m = 0; m < 4; m++) begin
      flow_sel = m[0]; order_sel = m[1];
      for (int i = 0; i < 700; i++) begin
        step(($urandom % 10) != 0, ($urandom % 3) != 0, $urandom % 2,
             AW'($urandom), NL'($urandom), DW'($urandom), ($urandom % 25) == 0);
      end
      idle(3);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule